// File: doc/BRIEF.md
# Discriminator Coincidence Cosmic Trigger

This block forms a cosmic-ray trigger primitive from four banks of sixteen discriminator lines each. Every line first passes through its own enable bit. The first enabled hit opens a short coincidence gate. Until the gate closes, every enabled line that goes active is collected. When the gate closes, the collected set is judged. If the judgement passes, a primitive pulse of programmable length is produced.

The judgement has three variants. The plain variant counts the collected lines and fires when the count is strictly above a threshold. The paired variant counts only channel pairs whose two members were both collected. A pair is either two neighbouring channels or two channels half a bank apart. The grid variant ignores the count and the threshold. It splits the banks into a lower group (A, B) and an upper group (C, D), then fires on the OR of the two groups' activity or on their AND. The primitive can be inverted in polarity. It is sent either to a cosmic-trigger output or to a test-trigger output.

The discriminator bus is already synchronous to the block clock. Configuration inputs are expected to stay steady while an event is in progress.

Top module: `cosmic_coinc_trig`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, with the mode inputs at zero polarity, both trigger outputs are low and no gate is open.
- R2: A discriminator line whose enable bit (same index in `mask_i`) is 0 neither opens a gate nor adds to the judgement.
- R3: A gate opens at the first clock edge that samples an enabled hit and collects enabled hits on W consecutive edges, where W is `win_len_i` (0 is taken as 1). Hits after those W edges do not join the event.
- R4: In plain mode (`mode_i[0]`=0, `mode_i[1]`=0), the primitive fires only when the number of collected channels is strictly greater than `thresh_i`.
- R5: When the judgement passes, the primitive goes active after the clock edge that is W edges after the opening edge. It stays active for L cycles, where L is `acc_len_i` (0 is taken as 1).
- R6: With `mode_i[1]`=1 and `mode_i[2]`=1, the count is the number of pairs (2k, 2k+1) within a bank whose two channels were both collected.
- R7: With `mode_i[1]`=1 and `mode_i[2]`=0, the count is the number of pairs (k, k+8) within a bank whose two channels were both collected.
- R8: With `mode_i[0]`=1, the threshold is not used. The primitive fires on (A|B)|(C|D) of bank activity when `mode_i[5]`=0, and on (A|B)&(C|D) when `mode_i[5]`=1. Bank A is channels 15:0, B is 31:16, C is 47:32 and D is 63:48.
- R9: With `mode_i[3]`=1, the routed output idles high and is driven low while the primitive is active.
- R10: With `mode_i[4]`=1 the primitive appears on `cosmic_o` and `test_o` stays low. With `mode_i[4]`=0 it appears on `test_o` and `cosmic_o` stays low.
- R11: No gate opens while the primitive is active, nor at the edge on which its last active cycle ends. With hits held continuously, the next primitive starts W+L+1+W cycles after the first opening edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| disc_i | input | 64 | Synchronous discriminator lines, bank A in bits 15:0 up to bank D in 63:48 |
| mask_i | input | 64 | Per-channel participation enables |
| thresh_i | input | 7 | Count threshold (fire when count exceeds it) |
| win_len_i | input | 4 | Coincidence gate length in clock cycles |
| acc_len_i | input | 8 | Primitive length in clock cycles |
| mode_i | input | 6 | 0 grid, 1 paired, 2 adjacent pairing, 3 invert, 4 route to cosmic, 5 grid AND |
| cosmic_o | output | 1 | Primitive routed as cosmic trigger |
| test_o | output | 1 | Primitive routed as test trigger |

## Verification
The bench builds the block with its default parameters: four banks of sixteen channels, a 4-bit gate length and an 8-bit pulse length. Every channel, every pair position and both bank groups are therefore reachable through directed vectors. Short gate and pulse settings, including the zero values treated as one, keep each event within a few dozen cycles. This lets the exact start cycle, pulse length and re-arm spacing be counted directly.

// File: rtl/cct_pkg.sv
package cct_pkg;

    // Mode word, MSB first: bit5 .. bit0
    typedef struct packed {
        logic grid_and;   // bit 5
        logic to_cosmic;  // bit 4
        logic invert;     // bit 3
        logic adjacent;   // bit 2
        logic paired;     // bit 1
        logic grid;       // bit 0
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_GATE = 2'd1,
        W_EVAL = 2'd2
    } win_st_e;

    // A programmed length of zero behaves as one
    function automatic int unsigned floor_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/cct_window.sv
module cct_window
    import cct_pkg::*;
#(
    parameter int CH_W  = 64,
    parameter int WIN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_W-1:0]   hits,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              busy,
    output logic              open_o,
    output logic              eval_o,
    output logic [CH_W-1:0]   lat_o
);

    win_st_e          st;
    logic [WIN_W-1:0] rem;

    assign open_o = (st == W_IDLE) && (|hits) && !busy;
    assign eval_o = (st == W_EVAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= W_IDLE;
            rem   <= '0;
            lat_o <= '0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (open_o) begin
                        lat_o <= hits;
                        if (win_len <= WIN_W'(1)) begin
                            st <= W_EVAL;
                        end else begin
                            st  <= W_GATE;
                            rem <= win_len - WIN_W'(1);
                        end
                    end
                end
                W_GATE: begin
                    lat_o <= lat_o | hits;
                    rem   <= rem - WIN_W'(1);
                    if (rem == WIN_W'(1)) st <= W_EVAL;
                end
                W_EVAL:  st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cct_evaluator.sv
module cct_evaluator #(
    parameter int N_BANKS = 4,
    parameter int BANK_W  = 16,
    parameter int THR_W   = 7,
    localparam int CH_W   = N_BANKS * BANK_W
) (
    input  logic [CH_W-1:0]  lat,
    input  logic             grid,
    input  logic             grid_and,
    input  logic             paired,
    input  logic             adjacent,
    input  logic [THR_W-1:0] thresh,
    output logic             fire_ok
);

    localparam int HALF   = BANK_W / 2;
    localparam int NPAIR  = N_BANKS * HALF;
    localparam int CNT_W  = $clog2(CH_W + 1);
    localparam int CMP_W  = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam int LO_GRP = N_BANKS / 2;

    logic [N_BANKS-1:0] bank_or;
    logic [NPAIR-1:0]   adj_pair;
    logic [NPAIR-1:0]   opp_pair;
    logic [NPAIR-1:0]   pair_sel;
    logic [CNT_W-1:0]   cnt_single;
    logic [CNT_W-1:0]   cnt_pair;
    logic [CNT_W-1:0]   count;
    logic               grp_lo;
    logic               grp_hi;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign bank_or[b] = |lat[b*BANK_W +: BANK_W];
        for (genvar k = 0; k < HALF; k++) begin : g_pair
            assign adj_pair[b*HALF + k] = lat[b*BANK_W + 2*k] & lat[b*BANK_W + 2*k + 1];
            assign opp_pair[b*HALF + k] = lat[b*BANK_W + k]   & lat[b*BANK_W + k + HALF];
        end
    end

    assign pair_sel = adjacent ? adj_pair : opp_pair;

    always_comb begin
        cnt_single = '0;
        for (int i = 0; i < CH_W; i++) cnt_single = cnt_single + CNT_W'(lat[i]);
    end

    always_comb begin
        cnt_pair = '0;
        for (int i = 0; i < NPAIR; i++) cnt_pair = cnt_pair + CNT_W'(pair_sel[i]);
    end

    assign count  = paired ? cnt_pair : cnt_single;
    assign grp_lo = |bank_or[LO_GRP-1:0];
    assign grp_hi = |bank_or[N_BANKS-1:LO_GRP];

    always_comb begin
        if (grid) fire_ok = grid_and ? (grp_lo & grp_hi) : (grp_lo | grp_hi);
        else      fire_ok = CMP_W'(count) > CMP_W'(thresh);
    end

endmodule

// File: rtl/cct_stretcher.sv
module cct_stretcher
    import cct_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    output logic             active
);

    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= LEN_W'(floor_one(32'(len)));
        end else if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
        end
    end

    assign active = (cnt != '0);

endmodule

// File: rtl/cosmic_coinc_trig.sv
module cosmic_coinc_trig
    import cct_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int BANK_W  = 16,
    parameter int THR_W   = 7,
    parameter int WIN_W   = 4,
    parameter int LEN_W   = 8,
    localparam int CH_W   = N_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_W-1:0]   disc_i,
    input  logic [CH_W-1:0]   mask_i,
    input  logic [THR_W-1:0]  thresh_i,
    input  logic [WIN_W-1:0]  win_len_i,
    input  logic [LEN_W-1:0]  acc_len_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              cosmic_o,
    output logic              test_o
);

    mode_t           md;
    logic [CH_W-1:0] hits;
    logic [CH_W-1:0] lat;
    logic            win_open;
    logic            win_eval;
    logic            fire_ok;
    logic            prim_active;
    logic            prim_lvl;

    assign md   = mode_t'(mode_i);
    assign hits = disc_i & mask_i;

    cct_window #(.CH_W(CH_W), .WIN_W(WIN_W)) u_window (
        .clk     (clk),
        .rst     (rst),
        .hits    (hits),
        .win_len (win_len_i),
        .busy    (prim_active),
        .open_o  (win_open),
        .eval_o  (win_eval),
        .lat_o   (lat)
    );

    cct_evaluator #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .THR_W(THR_W)) u_eval (
        .lat      (lat),
        .grid     (md.grid),
        .grid_and (md.grid_and),
        .paired   (md.paired),
        .adjacent (md.adjacent),
        .thresh   (thresh_i),
        .fire_ok  (fire_ok)
    );

    cct_stretcher #(.LEN_W(LEN_W)) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .fire   (win_eval & fire_ok),
        .len    (acc_len_i),
        .active (prim_active)
    );

    assign prim_lvl = prim_active ^ md.invert;
    assign cosmic_o = md.to_cosmic & prim_lvl;
    assign test_o   = !md.to_cosmic & prim_lvl;

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
    parameter int CH_W = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [CH_W-1:0] disc_i,
    input logic [CH_W-1:0] mask_i,
    input logic            route_cosmic,
    input logic            cosmic_o,
    input logic            test_o,
    input logic            win_open,
    input logic            win_eval,
    input logic            prim_active
);

    AST_NO_DUAL_ROUTE: assert property (@(posedge clk) disable iff (rst)
        !(cosmic_o && test_o));                                     // R10

    AST_TEST_QUIET: assert property (@(posedge clk) disable iff (rst)
        route_cosmic |-> !test_o);                                  // R10

    AST_OPEN_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (rst)
        win_open |-> |(disc_i & mask_i));                           // R2

    AST_BUSY_BLOCKS_OPEN: assert property (@(posedge clk) disable iff (rst)
        prim_active |-> !win_open);                                 // R11

    AST_RISE_AFTER_EVAL: assert property (@(posedge clk) disable iff (rst)
        $rose(prim_active) |-> $past(win_eval));                    // R5

    AST_EVAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        win_eval |=> !win_eval);                                    // R3

endmodule

bind cosmic_coinc_trig cct_checker #(.CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .disc_i       (disc_i),
    .mask_i       (mask_i),
    .route_cosmic (mode_i[4]),
    .cosmic_o     (cosmic_o),
    .test_o       (test_o),
    .win_open     (win_open),
    .win_eval     (win_eval),
    .prim_active  (prim_active)
);

// File: tb/cosmic_coinc_trig_bench.sv
module cosmic_coinc_trig_bench;

    localparam logic [5:0] M_GRID  = 6'b000001;
    localparam logic [5:0] M_PAIR  = 6'b000010;
    localparam logic [5:0] M_ADJ   = 6'b000100;
    localparam logic [5:0] M_INV   = 6'b001000;
    localparam logic [5:0] M_ROUTE = 6'b010000;
    localparam logic [5:0] M_AND   = 6'b100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] disc = '0;
    logic [63:0] mask = '1;
    logic [6:0]  thr  = 7'd2;
    logic [3:0]  wl   = 4'd2;
    logic [7:0]  al   = 8'd3;
    logic [5:0]  mode = M_ROUTE;
    logic        cosmic;
    logic        test;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    cosmic_coinc_trig u_cosmic_coinc_trig (
        .clk       (clk),
        .rst       (rst),
        .disc_i    (disc),
        .mask_i    (mask),
        .thresh_i  (thr),
        .win_len_i (wl),
        .acc_len_i (al),
        .mode_i    (mode),
        .cosmic_o  (cosmic),
        .test_o    (test)
    );

    function automatic logic [63:0] b(input int i);
        return 64'd1 << i;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive up to four vectors on consecutive edges (or hold v0), then
    // watch the routed output for span cycles after the first edge.
    task automatic shoot(input logic [63:0] v0, v1, v2, v3, input int nvec,
                         input bit hold, output int first, output int len,
                         output int second, output bit leak);
        logic [63:0] seq [4];
        bit run;
        bit ended;
        bit act;
        seq = '{v0, v1, v2, v3};
        first = -1; len = 0; second = -1; leak = 0; run = 0; ended = 0;
        @(negedge clk);
        disc = v0;
        @(posedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (hold)             disc = v0;
            else if (i + 1 < nvec) disc = seq[i + 1];
            else                   disc = '0;
            act = ((mode[4] ? cosmic : test) != mode[3]);
            if ((mode[4] ? test : cosmic) != 1'b0) leak = 1;
            if (act && first < 0) begin first = i; run = 1; end
            if (run && act) len++;
            if (run && !act) begin run = 0; ended = 1; end
            if (act && ended && second < 0) second = i;
        end
        disc = '0;
        repeat (24) @(posedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 cosmic in reset", int'(cosmic), 0);
        chk("R1 test in reset", int'(test), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cosmic after release", int'(cosmic), 0);
        chk("R1 test after release", int'(test), 0);
    endtask

    task automatic t_threshold;
        int f, l, s; bit k;
        mode = M_ROUTE; thr = 7'd2; wl = 4'd2; al = 8'd3;
        shoot(b(0)|b(21)|b(47), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R4 three over two start", f, 2);
        chk("R5 length three", l, 3);
        shoot(b(0)|b(21), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R4 two not over two", f, -1);
        thr = 7'd0;
        shoot(b(9), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R4 one over zero", f, 2);
    endtask

    task automatic t_window;
        int f, l, s; bit k;
        mode = M_ROUTE; thr = 7'd2; wl = 4'd3; al = 8'd3;
        shoot(b(0), b(20), b(40), '0, 3, 0, f, l, s, k);
        chk("R3 spread hits inside gate", f, 3);
        shoot(b(0), b(20), '0, b(40), 4, 0, f, l, s, k);
        chk("R3 late hit excluded", f, -1);
        wl = 4'd0;
        shoot(b(0)|b(1)|b(2), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R3 zero gate as one", f, 1);
        shoot(b(0)|b(1), b(2), '0, '0, 2, 0, f, l, s, k);
        chk("R3 zero gate excludes next edge", f, -1);
    endtask

    task automatic t_mask;
        int f, l, s; bit k;
        mode = M_ROUTE; thr = 7'd2; wl = 4'd2; al = 8'd3;
        mask = ~(b(62) | b(63));
        shoot(b(61)|b(62)|b(63), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R2 disabled lines not counted", f, -1);
        shoot(b(63), b(1)|b(2)|b(3), '0, '0, 2, 0, f, l, s, k);
        chk("R2 disabled line opens no gate", f, 3);
        mask = '1;
    endtask

    task automatic t_length;
        int f, l, s; bit k;
        mode = M_ROUTE; thr = 7'd0; wl = 4'd2; al = 8'd0;
        shoot(b(5), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R5 zero length start", f, 2);
        chk("R5 zero length as one", l, 1);
        al = 8'd5;
        shoot(b(5), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R5 length five", l, 5);
        al = 8'd3;
    endtask

    task automatic t_adjacent;
        int f, l, s; bit k;
        mode = M_ROUTE | M_PAIR | M_ADJ; thr = 7'd0; wl = 4'd2; al = 8'd3;
        shoot(b(2)|b(3), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R6 neighbour pair fires", f, 2);
        shoot(b(3)|b(4), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R6 straddling pair silent", f, -1);
        thr = 7'd1;
        shoot(b(2)|b(3)|b(18)|b(19), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R6 two pairs over one", f, 2);
    endtask

    task automatic t_opposite;
        int f, l, s; bit k;
        mode = M_ROUTE | M_PAIR; thr = 7'd0; wl = 4'd2; al = 8'd3;
        shoot(b(3)|b(11), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R7 opposite pair fires", f, 2);
        shoot(b(2)|b(3), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R7 neighbours silent", f, -1);
        shoot(b(19)|b(27), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R7 bank B opposite pair", f, 2);
    endtask

    task automatic t_grid;
        int f, l, s; bit k;
        mode = M_ROUTE | M_GRID; thr = 7'd100; wl = 4'd2; al = 8'd3;
        shoot(b(35), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R8 grid OR single bank C", f, 2);
        mode = M_ROUTE | M_GRID | M_AND;
        shoot(b(5), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R8 grid AND lower only", f, -1);
        shoot(b(5)|b(20), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R8 grid AND A and B only", f, -1);
        shoot(b(20)|b(60), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R8 grid AND B and D", f, 2);
    endtask

    task automatic t_invert;
        int f, l, s; bit k;
        mode = M_ROUTE | M_INV; thr = 7'd0; wl = 4'd2; al = 8'd3;
        @(negedge clk);
        chk("R9 idle level high", int'(cosmic), 1);
        shoot(b(0), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R9 low pulse start", f, 2);
        chk("R9 low pulse length", l, 3);
    endtask

    task automatic t_route;
        int f, l, s; bit k;
        mode = 6'b000000; thr = 7'd0; wl = 4'd2; al = 8'd3;
        shoot(b(0), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R10 test route start", f, 2);
        chk("R10 cosmic quiet", int'(k), 0);
        mode = M_ROUTE;
        shoot(b(0), '0, '0, '0, 1, 0, f, l, s, k);
        chk("R10 cosmic route start", f, 2);
        chk("R10 test quiet", int'(k), 0);
    endtask

    task automatic t_busy;
        int f, l, s; bit k;
        mode = M_ROUTE; thr = 7'd0; wl = 4'd3; al = 8'd4;
        shoot(b(7), '0, '0, '0, 1, 1, f, l, s, k);
        chk("R11 first start", f, 3);
        chk("R11 first length", l, 4);
        chk("R11 rearm spacing", s, 11);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_threshold();
        t_window();
        t_mask();
        t_length();
        t_adjacent();
        t_opposite();
        t_grid();
        t_invert();
        t_route();
        t_busy();
        summary();
    end

    initial begin
        #(20 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule